// File: doc/BRIEF.md
# Bias-Exception Branch Direction Predictor

This block predicts whether a conditional branch is taken. A direct-mapped choice table of 2-bit saturating counters, indexed by the low bits of the branch address, records each branch's usual direction (its bias). Two small 2-way set-associative tagged caches record only the cases where a branch departs from its bias: one holds entries that predict taken, the other entries that predict not taken. A lookup probes only the cache that is opposite to the bias. A tag hit there overrides the bias; a miss falls back to it. The cache set is chosen by the low address bits XORed with a folded global outcome history.

The predict port is combinational. It takes a branch address and returns the predicted direction together with a packed lookup record. The pipeline carries that record unchanged and hands it back on the resolve port with the real outcome. One cycle of resolve updates the choice counter, the used or newly allocated cache entry, the per-set replacement bit and the history register.

Top module: `bxp_predictor`

## Requirements
- R1: After reset every choice counter is weakly not taken (2'b01), both caches are empty and the history register is zero, so every prediction is not taken and reports no hit.
- R2: The bias is the high bit of the choice counter selected by the low CHOICE_BITS address bits. On a cache miss the prediction equals the bias.
- R3: A bias of taken probes only the not-taken cache, and a bias of not taken probes only the taken cache. On a tag hit the prediction is the high bit of the hit entry's counter. The record predInfo packs the set in bits [SET_BITS-1:0], the hit way (0 on a miss) in bit SET_BITS, the hit flag in bit SET_BITS+1, the bias in bit SET_BITS+2 and the prediction in bit SET_BITS+3.
- R4: The set index is the low SET_BITS address bits XORed with the history, folded by XORing history bit i into set bit i mod SET_BITS. The tag is the low TAG_W address bits. Way 0 wins when both ways match.
- R5: On resolve the choice counter saturates one step toward the outcome. It is left unchanged when the record shows a hit, the bias disagreed with the outcome, and the prediction was correct.
- R6: On resolve of a hit, the hit entry's counter saturates one step toward the outcome, provided that entry is still valid with the same tag, and that set's replacement state marks the other way as the next victim.
- R7: On resolve of a miss whose outcome disagrees with the bias, an entry is written in the probed cache at the recorded set. Its tag comes from the resolved address and its counter is 2'b10 for taken or 2'b01 for not taken. The other way becomes the next victim.
- R8: The allocation victim is an invalid way (way 0 first). Failing that, it is the only entry whose counter agrees with the bias (a redundant entry). Failing that, it is the least recently used way.
- R9: Every resolve shifts the outcome into the history register at bit 0.
- R10: While resValid is low the resolve inputs have no effect, and the prediction for a given address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| predPc | input | PC_W | Branch address to predict |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predInfo | output | SET_BITS+4 | Packed lookup record |
| resValid | input | 1 | Resolve strobe |
| resPc | input | PC_W | Address of the resolved branch |
| resTaken | input | 1 | Actual outcome, 1 = taken |
| resInfo | input | SET_BITS+4 | Record captured at prediction time |

## Verification
The assertions assume that every resolve carries a record that the predict port produced, and that it comes back before any other resolve has changed the history that record was built on. Otherwise the hit and set fields would refer to a different set. The bench meets this by predicting and then resolving each branch in the next cycle, one branch at a time, and by passing the design's own record back unchanged. The check that the resolve inputs are ignored when idle drives deliberately inconsistent records only while resValid is low.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

  typedef struct packed {
    logic       choiceWr;
    logic [1:0] choiceVal;
    logic       cntWr;
    logic       cntWay;
    logic [1:0] cntVal;
    logic       allocWr;
    logic       allocWay;
    logic [1:0] allocVal;
    logic       lruWr;
    logic       lruVictim;
    logic       histShift;
    logic       histBit;
  } bxpStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cnt, input logic up);
    logic [1:0] nxt;
    nxt = cnt;
    if (up && cnt != 2'b11) nxt = cnt + 2'b01;
    if (!up && cnt != 2'b00) nxt = cnt - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/bxp_datapath.sv
module bxp_datapath
  import bxp_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int CHOICE_BITS = 6,
  parameter int SET_BITS    = 4,
  parameter int TAG_W       = 6,
  parameter int HIST_W      = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PC_W-1:0]     lkPc,
  output logic                lkBias,
  output logic                lkHit,
  output logic                lkWay,
  output logic [SET_BITS-1:0] lkSet,
  output logic [1:0]          lkCnt,
  input  logic [PC_W-1:0]     rsPc,
  input  logic                rsSel,
  input  logic [SET_BITS-1:0] rsSet,
  input  bxpStrobe_t          strobe,
  output logic [1:0]          rdChoice,
  output logic [1:0]          rdValid,
  output logic [1:0]          rdTagHit,
  output logic [1:0]          rdCntA,
  output logic [1:0]          rdCntB,
  output logic                rdLru,
  output logic [HIST_W-1:0]   histOut
);
  localparam int CHOICE_N = 1 << CHOICE_BITS;
  localparam int SET_N    = 1 << SET_BITS;
  localparam int NUM_WAYS = 2;
  localparam int NUM_DIR  = 2;

  logic [1:0]       choiceTab [CHOICE_N];
  logic             validTab  [NUM_DIR][SET_N][NUM_WAYS];
  logic [TAG_W-1:0] tagTab    [NUM_DIR][SET_N][NUM_WAYS];
  logic [1:0]       cntTab    [NUM_DIR][SET_N][NUM_WAYS];
  logic             lruTab    [NUM_DIR][SET_N];
  logic [HIST_W-1:0] histReg;

  function automatic logic [SET_BITS-1:0] foldHist(input logic [HIST_W-1:0] h);
    logic [SET_BITS-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_W; i++) acc[i % SET_BITS] ^= h[i];
    return acc;
  endfunction

  // lookup side
  logic                lkSel;
  logic [NUM_WAYS-1:0] lkWayHit;
  logic [TAG_W-1:0]    lkTag;

  assign lkBias = choiceTab[lkPc[CHOICE_BITS-1:0]][1];
  assign lkSel  = lkBias;
  assign lkSet  = lkPc[SET_BITS-1:0] ^ foldHist(histReg);
  assign lkTag  = lkPc[TAG_W-1:0];

  // resolve side
  logic [TAG_W-1:0] rsTag;
  assign rsTag = rsPc[TAG_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign lkWayHit[w] = validTab[lkSel][lkSet][w] && (tagTab[lkSel][lkSet][w] == lkTag);
    assign rdValid[w]  = validTab[rsSel][rsSet][w];
    assign rdTagHit[w] = validTab[rsSel][rsSet][w] && (tagTab[rsSel][rsSet][w] == rsTag);
  end

  assign lkHit = |lkWayHit;
  assign lkWay = !lkWayHit[0] && lkWayHit[1];
  assign lkCnt = cntTab[lkSel][lkSet][lkWay];

  assign rdChoice = choiceTab[rsPc[CHOICE_BITS-1:0]];
  assign rdCntA   = cntTab[rsSel][rsSet][0];
  assign rdCntB   = cntTab[rsSel][rsSet][1];
  assign rdLru    = lruTab[rsSel][rsSet];
  assign histOut  = histReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CHOICE_N; i++) choiceTab[i] <= 2'b01;
      for (int d = 0; d < NUM_DIR; d++) begin
        for (int s = 0; s < SET_N; s++) begin
          lruTab[d][s] <= 1'b0;
          for (int w = 0; w < NUM_WAYS; w++) begin
            validTab[d][s][w] <= 1'b0;
            tagTab[d][s][w]   <= '0;
            cntTab[d][s][w]   <= 2'b00;
          end
        end
      end
      histReg <= '0;
    end else begin
      if (strobe.choiceWr) choiceTab[rsPc[CHOICE_BITS-1:0]] <= strobe.choiceVal;
      if (strobe.cntWr) cntTab[rsSel][rsSet][strobe.cntWay] <= strobe.cntVal;
      if (strobe.allocWr) begin
        validTab[rsSel][rsSet][strobe.allocWay] <= 1'b1;
        tagTab[rsSel][rsSet][strobe.allocWay]   <= rsTag;
        cntTab[rsSel][rsSet][strobe.allocWay]   <= strobe.allocVal;
      end
      if (strobe.lruWr) lruTab[rsSel][rsSet] <= strobe.lruVictim;
      if (strobe.histShift) histReg <= {histReg[HIST_W-2:0], strobe.histBit};
    end
  end

endmodule

// File: rtl/bxp_control.sv
module bxp_control
  import bxp_pkg::*;
(
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       infoPred,
  input  logic       infoBias,
  input  logic       infoHit,
  input  logic       infoWay,
  input  logic [1:0] rdChoice,
  input  logic [1:0] rdValid,
  input  logic [1:0] rdTagHit,
  input  logic [1:0] rdCntA,
  input  logic [1:0] rdCntB,
  input  logic       rdLru,
  output bxpStrobe_t strobe
);
  logic       keepChoice;
  logic       needAlloc;
  logic       entryLive;
  logic [1:0] usedCnt;
  logic [1:0] redundant;
  logic       victim;

  assign keepChoice = infoHit && (infoBias != resTaken) && (infoPred == resTaken);
  assign needAlloc  = resValid && !infoHit && (infoBias != resTaken);
  assign entryLive  = infoWay ? rdTagHit[1] : rdTagHit[0];
  assign usedCnt    = infoWay ? rdCntB : rdCntA;

  // an entry agreeing with the bias adds nothing over the choice table
  assign redundant[0] = rdValid[0] && (rdCntA[1] == infoBias);
  assign redundant[1] = rdValid[1] && (rdCntB[1] == infoBias);

  always_comb begin
    if (!rdValid[0])                     victim = 1'b0;
    else if (!rdValid[1])                victim = 1'b1;
    else if (redundant[0] ^ redundant[1]) victim = redundant[1];
    else                                 victim = rdLru;
  end

  always_comb begin
    strobe           = '0;
    strobe.choiceWr  = resValid && !keepChoice;
    strobe.choiceVal = satStep(rdChoice, resTaken);
    strobe.cntWr     = resValid && infoHit && entryLive;
    strobe.cntWay    = infoWay;
    strobe.cntVal    = satStep(usedCnt, resTaken);
    strobe.allocWr   = needAlloc;
    strobe.allocWay  = victim;
    strobe.allocVal  = resTaken ? 2'b10 : 2'b01;
    strobe.lruWr     = strobe.cntWr || needAlloc;
    strobe.lruVictim = strobe.cntWr ? !infoWay : !victim;
    strobe.histShift = resValid;
    strobe.histBit   = resTaken;
  end

endmodule

// File: rtl/bxp_predictor.sv
module bxp_predictor
  import bxp_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int CHOICE_BITS = 6,
  parameter int SET_BITS    = 4,
  parameter int TAG_W       = 6,
  parameter int HIST_W      = 6,
  localparam int INFO_W     = SET_BITS + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic [INFO_W-1:0] predInfo,
  input  logic              resValid,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic [INFO_W-1:0] resInfo
);
  localparam int WAY_POS  = SET_BITS;
  localparam int HIT_POS  = SET_BITS + 1;
  localparam int BIAS_POS = SET_BITS + 2;
  localparam int PRED_POS = SET_BITS + 3;

  logic                lkBias, lkHit, lkWay;
  logic [SET_BITS-1:0] lkSet;
  logic [1:0]          lkCnt;
  logic [1:0]          rdChoice, rdValid, rdTagHit, rdCntA, rdCntB;
  logic                rdLru;
  logic [HIST_W-1:0]   histReg;
  bxpStrobe_t          strobe;

  bxp_datapath #(
    .PC_W(PC_W), .CHOICE_BITS(CHOICE_BITS), .SET_BITS(SET_BITS),
    .TAG_W(TAG_W), .HIST_W(HIST_W)
  ) u_dp (
    .clk(clk), .rst(rst),
    .lkPc(predPc), .lkBias(lkBias), .lkHit(lkHit), .lkWay(lkWay),
    .lkSet(lkSet), .lkCnt(lkCnt),
    .rsPc(resPc), .rsSel(resInfo[BIAS_POS]), .rsSet(resInfo[SET_BITS-1:0]),
    .strobe(strobe),
    .rdChoice(rdChoice), .rdValid(rdValid), .rdTagHit(rdTagHit),
    .rdCntA(rdCntA), .rdCntB(rdCntB), .rdLru(rdLru), .histOut(histReg)
  );

  bxp_control u_ctl (
    .resValid(resValid), .resTaken(resTaken),
    .infoPred(resInfo[PRED_POS]), .infoBias(resInfo[BIAS_POS]),
    .infoHit(resInfo[HIT_POS]), .infoWay(resInfo[WAY_POS]),
    .rdChoice(rdChoice), .rdValid(rdValid), .rdTagHit(rdTagHit),
    .rdCntA(rdCntA), .rdCntB(rdCntB), .rdLru(rdLru),
    .strobe(strobe)
  );

  assign predTaken = lkHit ? lkCnt[1] : lkBias;
  assign predInfo  = {predTaken, lkBias, lkHit, lkWay, lkSet};

endmodule

// File: rtl/bxp_checker.sv
module bxp_checker #(
  parameter int PC_W     = 16,
  parameter int SET_BITS = 4,
  parameter int HIST_W   = 6,
  localparam int INFO_W  = SET_BITS + 4
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   predPc,
  input logic              predTaken,
  input logic [INFO_W-1:0] predInfo,
  input logic              resValid,
  input logic              resTaken,
  input logic [HIST_W-1:0] histReg
);
  assert_reset_hist_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> histReg == '0);

  assert_reset_nohit_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !predInfo[SET_BITS+1]);

  assert_hist_shift_R9: assert property (@(posedge clk) disable iff (rst)
    resValid |=> histReg == {$past(histReg[HIST_W-2:0]), $past(resTaken)});

  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !resValid |=> $stable(histReg));

  assert_pred_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !resValid |=> (predPc != $past(predPc)) || (predTaken == $past(predTaken)));

endmodule

bind bxp_predictor bxp_checker #(.PC_W(PC_W), .SET_BITS(SET_BITS), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .predPc(predPc), .predTaken(predTaken), .predInfo(predInfo),
  .resValid(resValid), .resTaken(resTaken), .histReg(histReg)
);

// File: tb/bxp_predictor_test.sv
module bxp_predictor_test;
  localparam int PC_W = 16, CB = 6, SB = 4, TW = 6, HW = 6;
  localparam int IW = SB + 4;
  localparam int NVEC = 24;
  // each entry: {outcome, pc}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'h0005}, {1'b1, 16'h0005}, {1'b0, 16'h0012}, {1'b1, 16'h0005},
    {1'b0, 16'h0005}, {1'b1, 16'h0105}, {1'b1, 16'h0033}, {1'b0, 16'h0033},
    {1'b1, 16'h0012}, {1'b1, 16'h0012}, {1'b0, 16'h0005}, {1'b1, 16'h0033},
    {1'b0, 16'h0105}, {1'b1, 16'h0027}, {1'b1, 16'h0027}, {1'b0, 16'h0027},
    {1'b1, 16'h0012}, {1'b0, 16'h0033}, {1'b1, 16'h0005}, {1'b1, 16'h0027},
    {1'b0, 16'h0012}, {1'b1, 16'h0105}, {1'b0, 16'h0005}, {1'b1, 16'h0033}
  };

  logic clk = 0, rst = 1;
  logic [PC_W-1:0] predPc = '0, resPc = '0;
  logic predTaken, resValid = 0, resTaken = 0;
  logic [IW-1:0] predInfo, resInfo = '0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bxp_predictor uut (
    .clk(clk), .rst(rst), .predPc(predPc), .predTaken(predTaken), .predInfo(predInfo),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken), .resInfo(resInfo)
  );

  // reference model
  logic [1:0]    mChoice [1<<CB];
  logic          mVal [2][1<<SB][2];
  logic [TW-1:0] mTag [2][1<<SB][2];
  logic [1:0]    mCnt [2][1<<SB][2];
  logic          mLru [2][1<<SB];
  logic [HW-1:0] mHist;

  function automatic logic [1:0] mSat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic mReset();
    for (int i = 0; i < (1<<CB); i++) mChoice[i] = 2'b01;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < (1<<SB); s++) begin
        mLru[d][s] = 0;
        for (int w = 0; w < 2; w++) begin mVal[d][s][w] = 0; mTag[d][s][w] = '0; mCnt[d][s][w] = '0; end
      end
    mHist = '0;
  endtask

  function automatic logic [IW-1:0] mPredict(input logic [PC_W-1:0] pc);
    logic bias, hit, way, tk;
    logic [SB-1:0] st;
    int d;
    bias = mChoice[pc[CB-1:0]][1];
    d = bias ? 1 : 0;
    st = pc[SB-1:0];
    for (int i = 0; i < HW; i++) st[i % SB] ^= mHist[i];
    hit = 0; way = 0;
    if (mVal[d][st][0] && mTag[d][st][0] == pc[TW-1:0]) hit = 1;
    else if (mVal[d][st][1] && mTag[d][st][1] == pc[TW-1:0]) begin hit = 1; way = 1; end
    tk = hit ? mCnt[d][st][way][1] : bias;
    return {tk, bias, hit, way, st};
  endfunction

  task automatic mResolve(input logic [PC_W-1:0] pc, input logic out, input logic [IW-1:0] inf);
    logic pr, bias, hit, way, v;
    logic [SB-1:0] st;
    logic [1:0] red;
    int d;
    {pr, bias, hit, way, st} = inf;
    d = bias ? 1 : 0;
    if (!(hit && bias != out && pr == out)) mChoice[pc[CB-1:0]] = mSat(mChoice[pc[CB-1:0]], out);
    if (hit) begin
      mCnt[d][st][way] = mSat(mCnt[d][st][way], out);
      mLru[d][st] = !way;
    end else if (bias != out) begin
      for (int w = 0; w < 2; w++) red[w] = mVal[d][st][w] && (mCnt[d][st][w][1] == bias);
      if (!mVal[d][st][0]) v = 0;
      else if (!mVal[d][st][1]) v = 1;
      else if (red == 2'b01) v = 0;
      else if (red == 2'b10) v = 1;
      else v = mLru[d][st];
      mVal[d][st][v] = 1; mTag[d][st][v] = pc[TW-1:0];
      mCnt[d][st][v] = out ? 2'b10 : 2'b01; mLru[d][st] = !v;
    end
    mHist = {mHist[HW-2:0], out};
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] pc, input logic out, input string tag);
    logic [IW-1:0] e;
    @(negedge clk);
    resValid = 0; predPc = pc; #1;
    e = mPredict(pc);
    chk(tag, {31'b0, predTaken}, {31'b0, e[IW-1]});
    chk(tag, {24'b0, predInfo}, {24'b0, e});
    resPc = pc; resTaken = out; resInfo = predInfo; resValid = 1;
    mResolve(pc, out, e);
  endtask

  task automatic probe(input logic [PC_W-1:0] pc, input string tag);
    logic [IW-1:0] e;
    @(negedge clk);
    resValid = 0; predPc = pc; #1;
    e = mPredict(pc);
    chk(tag, {24'b0, predInfo}, {24'b0, e});
  endtask

  task automatic flush(); // bring history to zero
    for (int i = 0; i < HW; i++) step(16'h0030, 1'b0, "R9");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    probe(16'h0005, "R1");
    probe(16'hbeef, "R1");
    @(negedge clk); #1; chk("R1", {31'b0, predTaken}, 32'd0);

    // first allocation then bias flip (R7, R2)
    step(16'h0005, 1'b1, "R7");
    step(16'h0005, 1'b1, "R2");

    // table walk: mixed branches, aliasing and history-driven sets (R4, R3, R5, R6)
    for (int i = 0; i < NVEC; i++) step(VEC[i][15:0], VEC[i][16], "R4");

    // replacement preference (R8)
    flush(); step(16'h0001, 1'b0, "R5");
    flush(); step(16'h0011, 1'b0, "R5");
    flush(); step(16'h0021, 1'b0, "R5");
    flush(); step(16'h0001, 1'b1, "R7");
    flush(); step(16'h0011, 1'b1, "R7");
    flush(); step(16'h0001, 1'b0, "R3");   // hit way0, counter becomes redundant
    flush(); step(16'h0021, 1'b1, "R8");   // redundant way0 chosen over LRU way1
    flush(); step(16'h0011, 1'b1, "R8");   // way1 must survive and hit
    flush(); step(16'h0021, 1'b1, "R6");
    flush(); probe(16'h0021, "R8");

    // history affects set selection (R9)
    step(16'h0021, 1'b1, "R9");
    step(16'h0021, 1'b1, "R9");
    probe(16'h0021, "R9");

    // R10: resolve inputs ignored while resValid is low
    @(negedge clk);
    resValid = 0; resPc = 16'h0021; resTaken = 1'b0;
    resInfo = {1'b1, 1'b0, 1'b1, 1'b1, 4'h3};
    repeat (3) @(negedge clk);
    probe(16'h0021, "R10");
    probe(16'h0005, "R10");

    // R1: reset in mid-run clears learnt state
    @(negedge clk); rst = 1; mReset();
    repeat (2) @(negedge clk); rst = 0;
    probe(16'h0021, "R1");
    probe(16'h0005, "R1");
    step(16'h0011, 1'b1, "R1");
    @(negedge clk); resValid = 0;
    @(negedge clk);
    finishRun();
  end

endmodule